// File: doc/BRIEF.md
# Memory Race Dependence Recorder

This per-core unit logs the ordering dependences that arise when one processor reads or overwrites data last touched by another. It keeps a running count of committed instructions and stamps each cache block with that count whenever a load or store to the block commits. When another core asks for a block, the unit replies with the block's stamp. If the block has already left the cache, the reply carries the stamp of the least recently used block in the same set as a conservative stand-in.

On the receiving side, each incoming coherence response brings the sender's core number and the sender's stamp for the block. A table with one entry per sender holds the largest stamp already logged from that sender. A dependence whose stamp is not above that entry is already implied by an earlier record, so it is dropped. A dependence that raises the entry updates the table and produces one log record. The record holds the sender number, the sender stamp and the local instruction count.

Top module: `race_dep_recorder`

## Requirements
- R1: While reset is low and immediately after it, the instruction count is 0, every block stamp is 0, every sender entry is 0, and no reply or log record is valid. An incoming stamp of 0 is therefore never logged until an entry has been raised.
- R2: The instruction count rises by exactly one on each cycle with `commit_valid` high and holds otherwise.
- R3: A commit with `commit_is_mem` high writes the count held before that commit into the stamp of block (`commit_set`, `commit_way`). A commit with `commit_is_mem` low leaves every stamp untouched.
- R4: A request raises `rsp_valid` on the following cycle and on no other. With `req_hit` high, `rsp_ts` equals the stamp of block (`req_set`, `req_way`) as it stood in the request cycle.
- R5: With `req_hit` low, `rsp_ts` equals the smallest stamp among the ways of `req_set`, taken as the least recently used block of that set.
- R6: An incoming response whose stamp is strictly greater than the entry for its sender produces, on the next cycle, `log_valid` high with that sender, that stamp and the local instruction count, and sets the entry to the stamp.
- R7: An incoming response whose stamp is less than or equal to the entry for its sender produces no log record and leaves the entry unchanged.
- R8: The entry of each sender is updated only by responses from that sender.
- R9: A response that names this core's own number (`SELF_ID`) is never logged and changes no entry.
- R10: When a response and a commit fall in the same cycle, the logged receiver count is the count held before that commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| commit_valid | input | 1 | One instruction commits this cycle |
| commit_is_mem | input | 1 | The committing instruction is a load or store |
| commit_set | input | idx_w(NUM_SETS) | Set of the block accessed |
| commit_way | input | idx_w(NUM_WAYS) | Way of the block accessed |
| req_valid | input | 1 | Another core requests a block stamp |
| req_set | input | idx_w(NUM_SETS) | Set of the requested block |
| req_way | input | idx_w(NUM_WAYS) | Way of the requested block when present |
| req_hit | input | 1 | Requested block is still cached |
| rsp_valid | output | 1 | Stamp reply valid |
| rsp_ts | output | TS_W | Stamp reply |
| in_valid | input | 1 | Incoming coherence response valid |
| in_sender | input | idx_w(NUM_CORES) | Core number of the sender |
| in_ts | input | TS_W | Sender's block stamp |
| log_valid | output | 1 | New dependence record valid |
| log_sender | output | idx_w(NUM_CORES) | Sender of the recorded dependence |
| log_sender_ts | output | TS_W | Sender stamp of the record |
| log_recv_ic | output | TS_W | Local instruction count of the record |
| instr_count | output | TS_W | Current instruction count |

## Verification
The bench builds the block with four cores, `SELF_ID` of 1, four sets of two ways and 12-bit stamps. At that size it writes and reads back every one of the eight blocks, checks the least-recently-used stand-in for every set after the way order has been reversed, and drives a stamp sequence through every sender entry, including the own-core slot and the largest stamp the width allows. An arithmetic model of the count, the stamps and the sender table gives the expected reply and log record for every cycle.

// File: rtl/rdr_pkg.sv
package rdr_pkg;

   // index width for a count of n items, never below one bit
   function automatic int unsigned idx_w(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

   function automatic bit is_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/rdr_instr_counter.sv
module rdr_instr_counter #(
   parameter int TS_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            step,
   output logic [TS_W-1:0] count
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (step)
         count <= count + 1'b1;
   end

endmodule

// File: rtl/rdr_stamp_store.sv
module rdr_stamp_store import rdr_pkg::*; #(
   parameter int TS_W     = 32,
   parameter int NUM_SETS = 16,
   parameter int NUM_WAYS = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [idx_w(NUM_SETS)-1:0]    wr_set,
   input  logic [idx_w(NUM_WAYS)-1:0]    wr_way,
   input  logic [TS_W-1:0]               wr_ts,
   input  logic                          rd_en,
   input  logic [idx_w(NUM_SETS)-1:0]    rd_set,
   input  logic [idx_w(NUM_WAYS)-1:0]    rd_way,
   input  logic                          rd_hit,
   output logic                          rsp_valid,
   output logic [TS_W-1:0]               rsp_ts
);

   localparam int WAY_W = idx_w(NUM_WAYS);

   logic [TS_W-1:0]  stamp_q [NUM_SETS][NUM_WAYS];
   logic [TS_W-1:0]  set_row [NUM_WAYS];
   logic [TS_W-1:0]  oldest_ts;
   logic [WAY_W-1:0] oldest_way;
   logic [TS_W-1:0]  pick_ts;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < NUM_SETS; s++)
            for (int w = 0; w < NUM_WAYS; w++)
               stamp_q[s][w] <= '0;
      end else if (wr_en) begin
         stamp_q[wr_set][wr_way] <= wr_ts;
      end
   end

   always_comb begin
      for (int w = 0; w < NUM_WAYS; w++)
         set_row[w] = stamp_q[rd_set][w];
   end

   // The stamps double as access times, so the oldest way is the one with
   // the smallest stamp; ties go to the lowest way.
   generate
      if (NUM_WAYS == 2) begin : g_pair
         always_comb begin
            if (set_row[1] < set_row[0]) begin
               oldest_ts  = set_row[1];
               oldest_way = 1'b1;
            end else begin
               oldest_ts  = set_row[0];
               oldest_way = 1'b0;
            end
         end
      end else begin : g_scan
         always_comb begin
            oldest_ts  = set_row[0];
            oldest_way = '0;
            for (int w = 1; w < NUM_WAYS; w++) begin
               if (set_row[w] < oldest_ts) begin
                  oldest_ts  = set_row[w];
                  oldest_way = WAY_W'(w);
               end
            end
         end
      end
   endgenerate

   assign pick_ts = rd_hit ? set_row[rd_way] : set_row[oldest_way];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_ts    <= '0;
      end else begin
         rsp_valid <= rd_en;
         if (rd_en)
            rsp_ts <= pick_ts;
      end
   end

   logic unused_oldest;
   assign unused_oldest = ^oldest_ts;

endmodule

// File: rtl/rdr_dep_filter.sv
module rdr_dep_filter import rdr_pkg::*; #(
   parameter int TS_W      = 32,
   parameter int NUM_CORES = 8,
   parameter int SELF_ID   = 0
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           in_valid,
   input  logic [idx_w(NUM_CORES)-1:0]    in_sender,
   input  logic [TS_W-1:0]                in_ts,
   input  logic [TS_W-1:0]                cur_ic,
   output logic                           log_valid,
   output logic [idx_w(NUM_CORES)-1:0]    log_sender,
   output logic [TS_W-1:0]                log_sender_ts,
   output logic [TS_W-1:0]                log_recv_ic
);

   localparam int ID_W = idx_w(NUM_CORES);

   logic [TS_W-1:0] seen_q [NUM_CORES];
   logic            sender_ok;
   logic            not_self;
   logic [TS_W-1:0] cur_entry;
   logic            raise;

   generate
      if (NUM_CORES == (1 << ID_W)) begin : g_full_ids
         assign sender_ok = 1'b1;
         assign cur_entry = seen_q[in_sender];
      end else begin : g_part_ids
         assign sender_ok = (int'(in_sender) < NUM_CORES);
         assign cur_entry = sender_ok ? seen_q[in_sender] : '1;
      end
   endgenerate

   assign not_self = (in_sender != ID_W'(SELF_ID));
   assign raise    = in_valid && sender_ok && not_self && (in_ts > cur_entry);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int p = 0; p < NUM_CORES; p++)
            seen_q[p] <= '0;
      end else if (raise) begin
         seen_q[in_sender] <= in_ts;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         log_valid     <= 1'b0;
         log_sender    <= '0;
         log_sender_ts <= '0;
         log_recv_ic   <= '0;
      end else begin
         log_valid <= raise;
         if (raise) begin
            log_sender    <= in_sender;
            log_sender_ts <= in_ts;
            log_recv_ic   <= cur_ic;
         end
      end
   end

endmodule

// File: rtl/race_dep_recorder.sv
module race_dep_recorder import rdr_pkg::*; #(
   parameter int NUM_CORES = 8,
   parameter int SELF_ID   = 0,
   parameter int TS_W      = 32,
   parameter int NUM_SETS  = 16,
   parameter int NUM_WAYS  = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          commit_valid,
   input  logic                          commit_is_mem,
   input  logic [idx_w(NUM_SETS)-1:0]    commit_set,
   input  logic [idx_w(NUM_WAYS)-1:0]    commit_way,
   input  logic                          req_valid,
   input  logic [idx_w(NUM_SETS)-1:0]    req_set,
   input  logic [idx_w(NUM_WAYS)-1:0]    req_way,
   input  logic                          req_hit,
   output logic                          rsp_valid,
   output logic [TS_W-1:0]               rsp_ts,
   input  logic                          in_valid,
   input  logic [idx_w(NUM_CORES)-1:0]   in_sender,
   input  logic [TS_W-1:0]               in_ts,
   output logic                          log_valid,
   output logic [idx_w(NUM_CORES)-1:0]   log_sender,
   output logic [TS_W-1:0]               log_sender_ts,
   output logic [TS_W-1:0]               log_recv_ic,
   output logic [TS_W-1:0]               instr_count
);

   generate
      if (NUM_CORES < 2) begin : g_bad_cores
         $error("NUM_CORES must be at least 2");
      end
      if (SELF_ID < 0 || SELF_ID >= NUM_CORES) begin : g_bad_self
         $error("SELF_ID must name one of the cores");
      end
      if (TS_W < 2) begin : g_bad_ts
         $error("TS_W must be at least 2");
      end
      if (NUM_SETS < 2 || !is_pow2(NUM_SETS)) begin : g_bad_sets
         $error("NUM_SETS must be a power of two, at least 2");
      end
      if (NUM_WAYS < 2 || !is_pow2(NUM_WAYS)) begin : g_bad_ways
         $error("NUM_WAYS must be a power of two, at least 2");
      end
   endgenerate

   logic stamp_wr;
   assign stamp_wr = commit_valid & commit_is_mem;

   rdr_instr_counter #(
      .TS_W (TS_W)
   ) u_count (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (commit_valid),
      .count (instr_count)
   );

   rdr_stamp_store #(
      .TS_W     (TS_W),
      .NUM_SETS (NUM_SETS),
      .NUM_WAYS (NUM_WAYS)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (stamp_wr),
      .wr_set    (commit_set),
      .wr_way    (commit_way),
      .wr_ts     (instr_count),
      .rd_en     (req_valid),
      .rd_set    (req_set),
      .rd_way    (req_way),
      .rd_hit    (req_hit),
      .rsp_valid (rsp_valid),
      .rsp_ts    (rsp_ts)
   );

   rdr_dep_filter #(
      .TS_W      (TS_W),
      .NUM_CORES (NUM_CORES),
      .SELF_ID   (SELF_ID)
   ) u_filter (
      .clk           (clk),
      .rst_n         (rst_n),
      .in_valid      (in_valid),
      .in_sender     (in_sender),
      .in_ts         (in_ts),
      .cur_ic        (instr_count),
      .log_valid     (log_valid),
      .log_sender    (log_sender),
      .log_sender_ts (log_sender_ts),
      .log_recv_ic   (log_recv_ic)
   );

endmodule

// File: rtl/rdr_checker.sv
module rdr_checker import rdr_pkg::*; #(
   parameter int NUM_CORES = 8,
   parameter int SELF_ID   = 0,
   parameter int TS_W      = 32
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          commit_valid,
   input logic                          req_valid,
   input logic                          rsp_valid,
   input logic                          in_valid,
   input logic [idx_w(NUM_CORES)-1:0]   in_sender,
   input logic [TS_W-1:0]               in_ts,
   input logic                          log_valid,
   input logic [idx_w(NUM_CORES)-1:0]   log_sender,
   input logic [TS_W-1:0]               log_sender_ts,
   input logic [TS_W-1:0]               log_recv_ic,
   input logic [TS_W-1:0]               instr_count
);

   localparam int ID_W = idx_w(NUM_CORES);

   // R1
   reset_state_chk: assert property (@(posedge clk)
      !rst_n |=> (instr_count == '0 && !log_valid && !rsp_valid));

   // R2
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_valid |=> instr_count == $past(instr_count) + 1'b1);

   // R2
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_valid |=> $stable(instr_count));

   // R4
   reply_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R4
   reply_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   // R6
   log_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      log_valid |-> ($past(in_valid) && log_sender == $past(in_sender)
                     && log_sender_ts == $past(in_ts)));

   // R7
   log_above_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      log_valid |-> log_sender_ts != '0);

   // R9
   log_not_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
      log_valid |-> log_sender != ID_W'(SELF_ID));

   // R10
   log_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      log_valid |-> log_recv_ic == $past(instr_count));

endmodule

bind race_dep_recorder rdr_checker #(
   .NUM_CORES (NUM_CORES),
   .SELF_ID   (SELF_ID),
   .TS_W      (TS_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .commit_valid  (commit_valid),
   .req_valid     (req_valid),
   .rsp_valid     (rsp_valid),
   .in_valid      (in_valid),
   .in_sender     (in_sender),
   .in_ts         (in_ts),
   .log_valid     (log_valid),
   .log_sender    (log_sender),
   .log_sender_ts (log_sender_ts),
   .log_recv_ic   (log_recv_ic),
   .instr_count   (instr_count)
);

// File: tb/race_dep_recorder_tb.sv
module race_dep_recorder_tb;

   localparam int NC    = 4;
   localparam int SELF  = 1;
   localparam int TSW   = 12;
   localparam int NS    = 4;
   localparam int NW    = 2;
   localparam int ID_W  = 2;
   localparam int SET_W = 2;
   localparam int WAY_W = 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             commit_valid = 1'b0, commit_is_mem = 1'b0;
   logic [SET_W-1:0] commit_set = '0;
   logic [WAY_W-1:0] commit_way = '0;
   logic             req_valid = 1'b0, req_hit = 1'b0;
   logic [SET_W-1:0] req_set = '0;
   logic [WAY_W-1:0] req_way = '0;
   logic             rsp_valid;
   logic [TSW-1:0]   rsp_ts;
   logic             in_valid = 1'b0;
   logic [ID_W-1:0]  in_sender = '0;
   logic [TSW-1:0]   in_ts = '0;
   logic             log_valid;
   logic [ID_W-1:0]  log_sender;
   logic [TSW-1:0]   log_sender_ts, log_recv_ic, instr_count;

   always #5 clk = ~clk;

   race_dep_recorder #(
      .NUM_CORES (NC), .SELF_ID (SELF), .TS_W (TSW),
      .NUM_SETS (NS), .NUM_WAYS (NW)
   ) u_dut (
      .clk (clk), .rst_n (rst_n),
      .commit_valid (commit_valid), .commit_is_mem (commit_is_mem),
      .commit_set (commit_set), .commit_way (commit_way),
      .req_valid (req_valid), .req_set (req_set), .req_way (req_way),
      .req_hit (req_hit), .rsp_valid (rsp_valid), .rsp_ts (rsp_ts),
      .in_valid (in_valid), .in_sender (in_sender), .in_ts (in_ts),
      .log_valid (log_valid), .log_sender (log_sender),
      .log_sender_ts (log_sender_ts), .log_recv_ic (log_recv_ic),
      .instr_count (instr_count)
   );

   int n_chk = 0;
   int n_err = 0;
   int m_ic = 0;
   int m_stamp [NS][NW];
   int m_seen [NC];

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int oldest(input int s);
      int best = m_stamp[s][0];
      for (int w = 1; w < NW; w++)
         if (m_stamp[s][w] < best) best = m_stamp[s][w];
      return best;
   endfunction

   // one clock cycle with full stimulus, model update and output checks
   task automatic cyc(input bit cv, input bit cm, input int cs, input int cw,
                      input bit rv, input int rs, input int rw, input bit rh,
                      input bit iv, input int snd, input int ts);
      int  e_rsp;
      int  e_ic;
      bit  take;
      e_rsp = rh ? m_stamp[rs][rw] : oldest(rs);
      e_ic  = m_ic;
      take  = iv && (snd != SELF) && (ts > m_seen[snd]);
      commit_valid = cv;  commit_is_mem = cm;
      commit_set = SET_W'(cs);  commit_way = WAY_W'(cw);
      req_valid = rv;  req_set = SET_W'(rs);  req_way = WAY_W'(rw);  req_hit = rh;
      in_valid = iv;  in_sender = ID_W'(snd);  in_ts = TSW'(ts);
      @(posedge clk);
      #1;
      if (cv) begin
         if (cm) m_stamp[cs][cw] = m_ic;
         m_ic++;
      end
      if (take) m_seen[snd] = ts;
      chk("R2", int'(instr_count), m_ic);
      chk("R4", int'(rsp_valid), int'(rv));
      if (rv) chk(rh ? "R4" : "R5", int'(rsp_ts), e_rsp);
      if (take) begin
         chk("R6", int'(log_valid), 1);
         chk("R6", int'(log_sender), snd);
         chk("R6", int'(log_sender_ts), ts);
         chk(cv ? "R10" : "R6", int'(log_recv_ic), e_ic);
      end else begin
         chk((iv && snd == SELF) ? "R9" : "R7", int'(log_valid), 0);
      end
      commit_valid = 1'b0;  req_valid = 1'b0;  in_valid = 1'b0;
   endtask

   task automatic idle();
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int ts_seq [8] = '{5, 3, 5, 6, 0, 200, 199, 4095};
      for (int s = 0; s < NS; s++)
         for (int w = 0; w < NW; w++) m_stamp[s][w] = 0;
      for (int p = 0; p < NC; p++) m_seen[p] = 0;

      repeat (3) @(posedge clk);
      #1;
      // R1: reset values at the ports
      chk("R1", int'(instr_count), 0);
      chk("R1", int'(log_valid), 0);
      chk("R1", int'(rsp_valid), 0);
      rst_n = 1'b1;

      // R1: every stamp reads back zero, a zero stamp is not logged
      for (int s = 0; s < NS; s++)
         for (int w = 0; w < NW; w++) begin
            cyc(0, 0, 0, 0, 1, s, w, 1, 0, 0, 0);
            chk("R1", int'(rsp_ts), 0);
         end
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
      chk("R1", int'(log_valid), 0);

      // R2: plain commits count without touching stamps
      for (int k = 0; k < 5; k++) cyc(1, 0, k % NS, k % NW, 0, 0, 0, 0, 0, 0, 0);
      idle();
      for (int s = 0; s < NS; s++) begin
         cyc(0, 0, 0, 0, 1, s, 1, 1, 0, 0, 0);
         chk("R3", int'(rsp_ts), 0);
      end

      // R3: memory commits to every block, interleaved with plain ones
      for (int k = 0; k < NS * NW; k++) begin
         cyc(1, 1, (k * 3) % NS, k / NS, 0, 0, 0, 0, 0, 0, 0);
         cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      end
      for (int s = 0; s < NS; s++)
         for (int w = 0; w < NW; w++) begin
            cyc(0, 0, 0, 0, 1, s, w, 1, 0, 0, 0);
            chk("R3", int'(rsp_ts), m_stamp[s][w]);
         end

      // R5: stand-in is the older way; reverse the order in two sets
      for (int s = 0; s < NS; s++) cyc(0, 0, 0, 0, 1, s, 1, 0, 0, 0, 0);
      cyc(1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      cyc(1, 1, 2, 0, 0, 0, 0, 0, 0, 0, 0);
      for (int s = 0; s < NS; s++) begin
         cyc(0, 0, 0, 0, 1, s, 0, 0, 0, 0, 0);
         chk("R5", int'(rsp_ts), oldest(s));
      end
      // R4: reply shows the stamp before a same-cycle commit to that block
      cyc(1, 1, 1, 1, 1, 1, 1, 1, 0, 0, 0);

      // R8: entries of different senders are independent
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 100);
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 2, 50);
      chk("R8", int'(log_valid), 1);
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 3, 100);
      chk("R8", int'(log_valid), 1);
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 50);
      chk("R8", int'(log_valid), 0);

      // R10: response and commit together log the pre-commit count
      cyc(1, 1, 3, 0, 0, 0, 0, 0, 1, 0, 300);
      chk("R10", int'(log_recv_ic), m_ic - 1);

      // R9: own core number is ignored, even with a large stamp
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, SELF, 4000);
      chk("R9", int'(log_valid), 0);
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, SELF, 10);
      chk("R9", int'(log_valid), 0);

      // R6 and R7: stamp sequence through every sender entry
      for (int p = 0; p < NC; p++)
         for (int k = 0; k < 8; k++)
            cyc(k[0], 1, (p + k) % NS, k % NW, k[1], k % NS, 0, k[2],
                1, p, ts_seq[k]);

      // R7: entries stay at the maximum
      for (int p = 0; p < NC; p++) begin
         cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, p, 4094);
         chk("R7", int'(log_valid), 0);
      end
      idle();
      finish_run();
   end

endmodule